// File: doc/BRIEF.md
# Four-Channel Cycle-Steal DMA Controller

This block moves data between memory and peripheral registers on a data bus that it shares with a CPU. It has four channels. Each channel holds one fixed peripheral-register address and one memory pointer. Every time a channel's request line is seen while that channel is enabled, the controller raises a bus request and waits for the CPU's grant. It then takes two bus cycles: one read beat and one write beat. After that it gives the bus back. The size of each transfer is one byte or one 16-bit word, chosen per channel.

After each transfer the channel moves its memory pointer on by the transfer size and counts its remaining transfers down by one. At the last transfer, a channel in single mode turns itself off. A channel in repeat mode instead reloads its count and its memory pointer from two reload registers and stays on. In both modes the last transfer raises a one-cycle done pulse. Channels are set up through a plain register write port that takes a channel number, a register select and a value. When several channels have a request pending at once, the lowest-numbered channel wins, and each bus grant carries exactly one transfer.

Top module: `dmacs_top`

## Requirements
- R1: After a synchronous reset, bus_req, bus_rd, bus_wr and every done bit are low. Every channel is disabled, so a request on any dreq line causes no bus activity.
- R2: A dreq pulse on an enabled channel causes exactly one transfer. A dreq pulse on a channel whose mode enable bit (bit 0) is 0 is ignored.
- R3: Any number of further dreq pulses on a channel that already has a request pending, and has not yet started its write beat, cause no additional transfer.
- R4: Among the pending channels, the lowest-numbered one is served first. Each grant carries a single transfer, and arbitration runs again after the bus is released.
- R5: The handshake runs in this order:
  - bus_req rises and stays high until the bus is granted.
  - In the first cycle after bus_gnt is sampled high, the read beat is driven (bus_rd).
  - In the next cycle, the write beat is driven (bus_wr).
  - In the cycle after the write beat, bus_req is low.
- R6: Mode bit 2 selects the direction.
  - When it is 0, the read beat uses the memory pointer and the write beat uses the peripheral address.
  - When it is 1, the read beat uses the peripheral address and the write beat uses the memory pointer.
  - The peripheral address never changes through transfers.
- R7: Mode bit 1 selects the size.
  - When it is 1 (word): bus_byte is low, the write data equals the 16-bit read data, and the memory pointer advances by 2.
  - When it is 0 (byte): bus_byte is high, the write data is the low read byte with the upper byte zero, and the memory pointer advances by 1.
- R8: Each transfer decrements the count by one. When the count is 1 or 0 before the transfer, the transfer is terminal. A terminal transfer raises that channel's done bit for exactly the one cycle after the write beat. In single mode (mode bit 3 = 0), a terminal transfer also clears the enable bit.
- R9: In repeat mode (mode bit 3 = 1), a terminal transfer loads the count from the count reload register and the memory pointer from the pointer reload register, and the channel stays enabled.
- R10: When cfg_we is high, cfg_wdata is written into the register of channel cfg_ch chosen by cfg_sel:
  - 0: mode (bit 0 enable, bit 1 word, bit 2 peripheral-to-memory, bit 3 repeat)
  - 1: count
  - 2: memory pointer
  - 3: peripheral address
  - 4: count reload
  - 5: pointer reload

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dreq | input | NUM_CH | Per-channel transfer request pulses |
| cfg_we | input | 1 | Setup register write strobe |
| cfg_ch | input | CH_W | Channel addressed by the setup write |
| cfg_sel | input | 3 | Register select within the channel |
| cfg_wdata | input | CFG_W | Setup write value |
| bus_req | output | 1 | Bus request to the CPU |
| bus_gnt | input | 1 | Bus grant from the CPU |
| bus_rd | output | 1 | Read beat strobe |
| bus_wr | output | 1 | Write beat strobe |
| bus_byte | output | 1 | High for a byte-sized beat |
| bus_addr | output | ADDR_W | Beat address |
| bus_wdata | output | 16 | Write beat data |
| bus_rdata | input | 16 | Read data, sampled at the end of the read beat |
| done | output | NUM_CH | One-cycle terminal-transfer pulse per channel |

## Verification
The bench builds the block with its defaults: four channels, 16-bit addresses and 16-bit counts. This makes it possible to collide requests on all four channels at once, which exercises the priority order over the full channel set. The bench holds the grant back so that repeated requests pile up on a pending channel. It also varies the grant delay between zero and three cycles. Small counts and reload values bring single-mode shutdown and repeated repeat-mode reloads into reach within a few requests, with byte and word sizes and both directions mixed in.

// File: rtl/dmacs_pkg.sv
package dmacs_pkg;

    localparam int BUS_DW = 16;

    localparam logic [2:0] SEL_MODE  = 3'd0;
    localparam logic [2:0] SEL_CNT   = 3'd1;
    localparam logic [2:0] SEL_MPTR  = 3'd2;
    localparam logic [2:0] SEL_PER   = 3'd3;
    localparam logic [2:0] SEL_CNTRL = 3'd4;
    localparam logic [2:0] SEL_MPRL  = 3'd5;

    // bit 0 = en, bit 1 = word, bit 2 = p2m, bit 3 = rpt
    typedef struct packed {
        logic rpt;
        logic p2m;
        logic word;
        logic en;
    } mode_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_REQ,
        SQ_RD,
        SQ_WR,
        SQ_REL
    } seq_state_e;

    function automatic logic [BUS_DW-1:0] size_data(input logic word,
                                                    input logic [BUS_DW-1:0] d);
        return word ? d : {8'h00, d[7:0]};
    endfunction

endpackage

// File: rtl/dmacs_chan.sv
module dmacs_chan
    import dmacs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int CFG_W  = 16,
    parameter int CH_W   = 2,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_in,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              xfer,
    output logic              pend,
    output mode_t             mode,
    output logic [ADDR_W-1:0] mem_ptr,
    output logic [ADDR_W-1:0] per_addr,
    output logic              done
);

    logic [CNT_W-1:0]  cnt, cnt_rl;
    logic [ADDR_W-1:0] mptr_rl;

    mode_t             mode_n;
    logic [CNT_W-1:0]  cnt_n, cnt_rl_n;
    logic [ADDR_W-1:0] mptr_n, per_n, mptr_rl_n, step;
    logic              done_n, pend_n, hit;

    assign hit  = cfg_we && (cfg_ch == CH_W'(IDX));
    assign step = mode.word ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        mode_n    = mode;
        cnt_n     = cnt;
        cnt_rl_n  = cnt_rl;
        mptr_n    = mem_ptr;
        mptr_rl_n = mptr_rl;
        per_n     = per_addr;
        done_n    = 1'b0;
        if (xfer) begin
            if (cnt <= CNT_W'(1)) begin
                done_n = 1'b1;
                if (mode.rpt) begin
                    cnt_n  = cnt_rl;
                    mptr_n = mptr_rl;
                end else begin
                    mode_n.en = 1'b0;
                    cnt_n     = '0;
                    mptr_n    = mem_ptr + step;
                end
            end else begin
                cnt_n  = cnt - CNT_W'(1);
                mptr_n = mem_ptr + step;
            end
        end
        if (hit) begin
            case (cfg_sel)
                SEL_MODE:  mode_n    = mode_t'(cfg_wdata[3:0]);
                SEL_CNT:   cnt_n     = cfg_wdata[CNT_W-1:0];
                SEL_MPTR:  mptr_n    = cfg_wdata[ADDR_W-1:0];
                SEL_PER:   per_n     = cfg_wdata[ADDR_W-1:0];
                SEL_CNTRL: cnt_rl_n  = cfg_wdata[CNT_W-1:0];
                SEL_MPRL:  mptr_rl_n = cfg_wdata[ADDR_W-1:0];
                default:   ;
            endcase
        end
        pend_n = ((pend && !xfer) || (req_in && mode.en)) && mode_n.en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            cnt      <= '0;
            cnt_rl   <= '0;
            mem_ptr  <= '0;
            mptr_rl  <= '0;
            per_addr <= '0;
            done     <= 1'b0;
            pend     <= 1'b0;
        end else begin
            mode     <= mode_n;
            cnt      <= cnt_n;
            cnt_rl   <= cnt_rl_n;
            mem_ptr  <= mptr_n;
            mptr_rl  <= mptr_rl_n;
            per_addr <= per_n;
            done     <= done_n;
            pend     <= pend_n;
        end
    end

endmodule

// File: rtl/dmacs_arb.sv
module dmacs_arb #(
    parameter int N    = 4,
    parameter int CH_W = 2
) (
    input  logic [N-1:0]    pend,
    output logic            any,
    output logic [CH_W-1:0] pick
);

    always_comb begin
        pick = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) pick = CH_W'(i);
        end
    end

    assign any = |pend;

endmodule

// File: rtl/dmacs_seq.sv
module dmacs_seq
    import dmacs_pkg::*;
#(
    parameter int CH_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            any,
    input  logic [CH_W-1:0] pick,
    input  logic            gnt,
    output seq_state_e      state,
    output logic [CH_W-1:0] cur
);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cur   <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (any) begin
                    cur   <= pick;
                    state <= SQ_REQ;
                end
                SQ_REQ:  if (gnt) state <= SQ_RD;
                SQ_RD:   state <= SQ_WR;
                SQ_WR:   state <= SQ_REL;
                SQ_REL:  state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmacs_top.sv
module dmacs_top
    import dmacs_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int CFG_W = (ADDR_W > CNT_W) ? ADDR_W : CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] dreq,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [2:0]        cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_byte,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BUS_DW-1:0] bus_wdata,
    input  logic [BUS_DW-1:0] bus_rdata,
    output logic [NUM_CH-1:0] done
);

    logic [NUM_CH-1:0] pend_vec;
    mode_t             ch_mode [NUM_CH];
    logic [ADDR_W-1:0] ch_mptr [NUM_CH];
    logic [ADDR_W-1:0] ch_per  [NUM_CH];

    seq_state_e        state;
    logic [CH_W-1:0]   cur, pick;
    logic              any;
    logic [BUS_DW-1:0] data_q;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            dmacs_chan #(
                .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W),
                .CH_W(CH_W), .IDX(g)
            ) u_chan (
                .clk      (clk),
                .rst      (rst),
                .req_in   (dreq[g]),
                .cfg_we   (cfg_we),
                .cfg_ch   (cfg_ch),
                .cfg_sel  (cfg_sel),
                .cfg_wdata(cfg_wdata),
                .xfer     ((state == SQ_WR) && (cur == CH_W'(g))),
                .pend     (pend_vec[g]),
                .mode     (ch_mode[g]),
                .mem_ptr  (ch_mptr[g]),
                .per_addr (ch_per[g]),
                .done     (done[g])
            );
        end
    endgenerate

    dmacs_arb #(.N(NUM_CH), .CH_W(CH_W)) u_arb (
        .pend(pend_vec), .any(any), .pick(pick)
    );

    dmacs_seq #(.CH_W(CH_W)) u_seq (
        .clk(clk), .rst(rst), .any(any), .pick(pick),
        .gnt(bus_gnt), .state(state), .cur(cur)
    );

    mode_t             s_mode;
    logic [ADDR_W-1:0] s_src, s_dst;

    always_comb begin
        s_mode = ch_mode[cur];
        s_src  = s_mode.p2m ? ch_per[cur] : ch_mptr[cur];
        s_dst  = s_mode.p2m ? ch_mptr[cur] : ch_per[cur];
    end

    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else if (state == SQ_RD) data_q <= size_data(s_mode.word, bus_rdata);
    end

    always_comb begin
        bus_req   = (state == SQ_REQ) || (state == SQ_RD) || (state == SQ_WR);
        bus_rd    = (state == SQ_RD);
        bus_wr    = (state == SQ_WR);
        bus_byte  = (bus_rd || bus_wr) && !s_mode.word;
        bus_addr  = bus_rd ? s_src : (bus_wr ? s_dst : '0);
        bus_wdata = bus_wr ? data_q : '0;
    end

endmodule

// File: rtl/dmacs_chk.sv
module dmacs_chk #(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              bus_byte,
    input logic [NUM_CH-1:0] done
);

    // R5
    rd_needs_gnt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_rd) |-> $past(bus_gnt));

    // R5
    wr_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> (bus_wr && !bus_rd));

    // R5
    release_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_req);

    // R5
    beat_under_req_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd || bus_wr) |-> bus_req);

    // R2
    no_rd_from_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_req |=> !bus_rd);

    // R8
    done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    // R8
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (|done) |-> $past(bus_wr));

    // R7
    size_stable_chk: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> (bus_byte == $past(bus_byte)));

endmodule

bind dmacs_top dmacs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_byte(bus_byte),
    .done    (done)
);

// File: tb/tb_dmacs_top.sv
`timescale 1ns/100ps
module tb_dmacs_top;

    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  dreq;
    logic        cfg_we;
    logic [1:0]  cfg_ch;
    logic [2:0]  cfg_sel;
    logic [15:0] cfg_wdata;
    logic        bus_req, bus_gnt, bus_rd, bus_wr, bus_byte;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic [3:0]  done;

    always #2.5 clk = ~clk;

    dmacs_top dut (
        .clk(clk), .rst(rst), .dreq(dreq), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_byte(bus_byte),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .done(done)
    );

    logic [7:0] dut_mem [256];
    logic [7:0] exp_mem [256];

    assign bus_rdata = {dut_mem[bus_addr[7:0] + 8'd1], dut_mem[bus_addr[7:0]]};

    always @(posedge clk) begin
        if (bus_wr) begin
            dut_mem[bus_addr[7:0]] <= bus_wdata[7:0];
            if (!bus_byte) dut_mem[bus_addr[7:0] + 8'd1] <= bus_wdata[15:8];
        end
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int init_byte(input int i);
        return (i * 7 + 3) & 255;
    endfunction

    // grant generator
    bit gnt_en = 1'b1;
    int gnt_delay = 1;
    int wcnt = 0;
    always @(negedge clk) begin
        if (!bus_req) begin
            bus_gnt <= 1'b0;
            wcnt = 0;
        end else if (!bus_gnt) begin
            if (gnt_en && wcnt >= gnt_delay) bus_gnt <= 1'b1;
            else wcnt++;
        end
    end

    // behavioural reference model
    int ms, mcur;
    bit m_en[NC], m_word[NC], m_dir[NC], m_rpt[NC], m_pend[NC], m_done[NC];
    int m_cnt[NC], m_mptr[NC], m_per[NC], m_crl[NC], m_mrl[NC];
    int m_data;
    bit old_pend[NC], old_en[NC];
    bit e_req, e_rd, e_wr, e_byte;
    int e_addr, e_wdata;
    int ta, tv, stp, k;
    bit anyp;

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mcur = 0; m_data = 0;
            for (int i = 0; i < NC; i++) begin
                m_en[i] = 0; m_word[i] = 0; m_dir[i] = 0; m_rpt[i] = 0;
                m_pend[i] = 0; m_done[i] = 0; m_cnt[i] = 0; m_mptr[i] = 0;
                m_per[i] = 0; m_crl[i] = 0; m_mrl[i] = 0;
            end
        end else begin
            // bus beats use the registers as they stood before this edge
            if (ms == 2) begin
                ta = (m_dir[mcur] ? m_per[mcur] : m_mptr[mcur]) & 255;
                tv = {exp_mem[(ta + 1) & 255], exp_mem[ta]};
                m_data = m_word[mcur] ? tv : (tv & 255);
            end
            if (ms == 3) begin
                ta = (m_dir[mcur] ? m_mptr[mcur] : m_per[mcur]) & 255;
                exp_mem[ta] = m_data[7:0];
                if (m_word[mcur]) exp_mem[(ta + 1) & 255] = m_data[15:8];
            end
            for (int i = 0; i < NC; i++) begin
                old_pend[i] = m_pend[i];
                old_en[i]   = m_en[i];
                m_done[i]   = 0;
            end
            if (ms == 3) begin
                stp = m_word[mcur] ? 2 : 1;
                if (m_cnt[mcur] <= 1) begin
                    m_done[mcur] = 1;
                    if (m_rpt[mcur]) begin
                        m_cnt[mcur]  = m_crl[mcur];
                        m_mptr[mcur] = m_mrl[mcur];
                    end else begin
                        m_en[mcur]   = 0;
                        m_cnt[mcur]  = 0;
                        m_mptr[mcur] = (m_mptr[mcur] + stp) & 16'hFFFF;
                    end
                end else begin
                    m_cnt[mcur]  = m_cnt[mcur] - 1;
                    m_mptr[mcur] = (m_mptr[mcur] + stp) & 16'hFFFF;
                end
            end
            if (cfg_we) begin
                k = int'(cfg_ch);
                case (cfg_sel)
                    3'd0: begin
                        m_en[k] = cfg_wdata[0]; m_word[k] = cfg_wdata[1];
                        m_dir[k] = cfg_wdata[2]; m_rpt[k] = cfg_wdata[3];
                    end
                    3'd1: m_cnt[k]  = int'(cfg_wdata);
                    3'd2: m_mptr[k] = int'(cfg_wdata);
                    3'd3: m_per[k]  = int'(cfg_wdata);
                    3'd4: m_crl[k]  = int'(cfg_wdata);
                    3'd5: m_mrl[k]  = int'(cfg_wdata);
                    default: ;
                endcase
            end
            for (int i = 0; i < NC; i++) begin
                m_pend[i] = ((old_pend[i] && !(ms == 3 && mcur == i)) ||
                             (dreq[i] && old_en[i])) && m_en[i];
            end
            case (ms)
                0: begin
                    anyp = 0;
                    for (int i = 0; i < NC; i++) begin
                        if (old_pend[i] && !anyp) begin
                            anyp = 1; mcur = i;
                        end
                    end
                    if (anyp) ms = 1;
                end
                1: if (bus_gnt) ms = 2;
                2: ms = 3;
                3: ms = 4;
                default: ms = 0;
            endcase
        end
        e_req  = (ms == 1) || (ms == 2) || (ms == 3);
        e_rd   = (ms == 2);
        e_wr   = (ms == 3);
        e_byte = (e_rd || e_wr) && !m_word[mcur];
        e_addr = e_rd ? (m_dir[mcur] ? m_per[mcur] : m_mptr[mcur]) :
                 e_wr ? (m_dir[mcur] ? m_mptr[mcur] : m_per[mcur]) : 0;
        e_wdata = e_wr ? m_data : 0;
    end

    // per-cycle comparison and observation logs
    int wr_log[$];
    int done_cnt[NC];
    always @(negedge clk) begin
        if (!rst) begin
            chk({bus_req, bus_rd, bus_wr} == {e_req, e_rd, e_wr},
                "R5 handshake req/rd/wr", {bus_req, bus_rd, bus_wr}, {e_req, e_rd, e_wr});
            chk(int'(bus_addr) == e_addr, "R6 R10 beat address", bus_addr, e_addr);
            chk(bus_byte == e_byte && int'(bus_wdata) == e_wdata,
                "R7 size and write data", {bus_byte, bus_wdata}, {e_byte, e_wdata[15:0]});
            chk(done == {m_done[3], m_done[2], m_done[1], m_done[0]},
                "R8 R9 done pulses", done, {m_done[3], m_done[2], m_done[1], m_done[0]});
            if (bus_wr) wr_log.push_back(int'(bus_addr));
            for (int i = 0; i < NC; i++) if (done[i]) done_cnt[i]++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input int ch, input int sel, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = ch[1:0]; cfg_sel = sel[2:0]; cfg_wdata = val[15:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        dreq = m;
        @(negedge clk);
        dreq = 4'h0;
    endtask

    int d0, d1;

    initial begin
        #(100000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            dut_mem[i] = init_byte(i)[7:0];
            exp_mem[i] = init_byte(i)[7:0];
        end
        for (int i = 0; i < NC; i++) done_cnt[i] = 0;
        rst = 1'b1; dreq = '0; cfg_we = 0; cfg_ch = 0; cfg_sel = 0; cfg_wdata = 0;
        bus_gnt = 1'b0;
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!bus_req && !bus_rd && !bus_wr && done == 4'h0, "R1 reset outputs",
            {bus_req, bus_rd, bus_wr, done}, 0);
        pulse(4'hF);
        cyc(10);
        chk(wr_log.size() == 0, "R1 all channels disabled after reset", wr_log.size(), 0);

        // R2 R6 R7 R8: single byte memory-to-peripheral
        cfg_write(0, 3, 'hF0);
        cfg_write(0, 2, 'h10);
        cfg_write(0, 1, 3);
        cfg_write(0, 0, 'h1);
        for (int i = 0; i < 3; i++) begin
            pulse(4'h1);
            cyc(10);
        end
        chk(wr_log.size() == 3, "R2 one transfer per request", wr_log.size(), 3);
        chk(done_cnt[0] == 1, "R8 single done count", done_cnt[0], 1);
        chk(int'(dut_mem['hF0]) == init_byte('h12), "R7 R8 last byte moved",
            dut_mem['hF0], init_byte('h12));
        pulse(4'h1);
        cyc(10);
        chk(wr_log.size() == 3, "R8 single mode disables channel", wr_log.size(), 3);

        // R9 R6 R7: repeat word peripheral-to-memory
        wr_log.delete();
        d1 = done_cnt[1];
        cfg_write(1, 3, 'h80);
        cfg_write(1, 2, 'h40);
        cfg_write(1, 1, 2);
        cfg_write(1, 4, 2);
        cfg_write(1, 5, 'h60);
        cfg_write(1, 0, 'hF);
        for (int i = 0; i < 5; i++) begin
            pulse(4'h2);
            cyc(10);
        end
        chk(wr_log.size() == 5, "R9 repeat stays enabled", wr_log.size(), 5);
        if (wr_log.size() == 5) begin
            chk(wr_log[1] == 'h42, "R7 word step of two", wr_log[1], 'h42);
            chk(wr_log[2] == 'h60, "R9 pointer reloaded", wr_log[2], 'h60);
            chk(wr_log[4] == 'h60, "R9 second reload", wr_log[4], 'h60);
        end
        chk(done_cnt[1] - d1 == 2, "R9 done per block", done_cnt[1] - d1, 2);
        chk(int'(dut_mem['h62]) == init_byte('h80) && int'(dut_mem['h63]) == init_byte('h81),
            "R6 R7 word from peripheral", {dut_mem['h63], dut_mem['h62]},
            {init_byte('h81), init_byte('h80)});

        // R4: simultaneous requests on all channels
        cfg_write(0, 3, 'hF0); cfg_write(0, 2, 'h20); cfg_write(0, 1, 5); cfg_write(0, 0, 1);
        cfg_write(1, 3, 'hF4); cfg_write(1, 2, 'h30); cfg_write(1, 1, 5); cfg_write(1, 0, 1);
        cfg_write(2, 3, 'hF8); cfg_write(2, 2, 'h38); cfg_write(2, 1, 5); cfg_write(2, 0, 1);
        cfg_write(3, 3, 'hFC); cfg_write(3, 2, 'h3C); cfg_write(3, 1, 5); cfg_write(3, 0, 1);
        cyc(5);
        wr_log.delete();
        pulse(4'hF);
        cyc(40);
        chk(wr_log.size() == 4, "R4 four grants", wr_log.size(), 4);
        if (wr_log.size() == 4) begin
            for (int i = 0; i < 4; i++)
                chk(wr_log[i] == 'hF0 + 4 * i, "R4 lowest channel first", wr_log[i], 'hF0 + 4 * i);
        end

        // R3 R2: repeated requests while pending, request on disabled channel
        cfg_write(3, 0, 0);
        cyc(3);
        wr_log.delete();
        gnt_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            pulse(4'h4);
            cyc(2);
        end
        pulse(4'h8);
        cyc(4);
        gnt_en = 1'b1;
        cyc(30);
        chk(wr_log.size() == 1, "R3 pending request latched once", wr_log.size(), 1);
        if (wr_log.size() == 1)
            chk(wr_log[0] == 'hF8, "R2 disabled channel ignored", wr_log[0], 'hF8);

        // random traffic, varied grant delay
        for (int r = 0; r < 6; r++) begin
            gnt_delay = $urandom_range(0, 3);
            for (int c = 0; c < NC; c++) begin
                cfg_write(c, 3, 'hC0 + 8 * c);
                cfg_write(c, 2, $urandom_range(0, 127));
                cfg_write(c, 1, $urandom_range(1, 4));
                cfg_write(c, 4, $urandom_range(1, 4));
                cfg_write(c, 5, $urandom_range(0, 127));
                cfg_write(c, 0, 1 | ($urandom_range(0, 7) << 1));
            end
            for (int t = 0; t < 80; t++) begin
                @(negedge clk);
                dreq = 4'($urandom_range(0, 15) & $urandom_range(0, 15));
            end
            @(negedge clk);
            dreq = 4'h0;
            cyc(70);
        end

        d0 = 0;
        for (int i = 0; i < 256; i++) if (dut_mem[i] !== exp_mem[i]) d0++;
        chk(d0 == 0, "R6 R7 memory image", d0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule